// File: doc/BRIEF.md
# Clock Output Enable Gate

This block sits between a bank of divided clocks and the pins they drive. Each channel has an enable bit and a power-down bit, and both may change at any moment. The block makes sure that an enable change never clips a pulse on the output.

The divided clocks are sampled in the fast source clock domain. Each channel's enable bit first passes through a synchroniser. It is then acted on only at a falling edge of that channel's own divided clock, when the clock has just gone low. The output therefore opens or closes between complete pulses. Channels that share a divide ratio and phase see their falling edges on the same source cycle, so they switch together.

Power-down is also synchronised. It wins over enable: it pulls the output low at once and closes the gate. After power-down is released, the gate waits for the next falling edge before it opens again.

Top module: `oeg_gate`

## Requirements
- R1: While reset is held, and in the cycles after it until an enable has taken effect, every output is low.
- R2: While a channel is open and not powered down, its output copies that channel's divided clock delayed by one source cycle. Every high and low pulse keeps the divided clock's half-period.
- R3: An enable bit set to 1 passes through two synchroniser stages. It then opens the gate at the first falling edge of the divided clock (low after high). The first output pulse after enabling is a full-width high pulse.
- R4: An enable bit cleared to 0 closes the gate at a falling edge only. The last high pulse keeps full width, and the output then stays low.
- R5: When the divided clock has no falling edge, an enable change has no effect on the output. This holds whether the clock is held static low or static high.
- R6: Two channels with equal ratio and phase, enabled or disabled in the same cycle, produce identical outputs on every cycle.
- R7: Power-down set to 1 forces the output low by the third source clock rising edge after it is applied. This holds regardless of the enable bit or the phase of the divided clock, and the output stays low while power-down is held.
- R8: After power-down is released with enable at 1, the output resumes only after a falling edge of the divided clock, and with full-width pulses.
- R9: Channels are independent: enabling one channel produces no pulse on another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; all sampling and gating happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| div_clk_i | input | N_CHAN | Divided clocks, one bit per channel, synchronous to clk |
| en_i | input | N_CHAN | Per-channel enable bits, asynchronous to the divided clocks |
| pd_i | input | N_CHAN | Per-channel power-down bits; 1 forces the output low |
| clk_o | output | N_CHAN | Gated clock outputs |

## Verification
Once a channel is open, its output is due one source cycle after the divided clock. The bench therefore compares each output with the divided-clock value it drove before the last rising edge, sampling on the falling edge of the source clock.

An enable change needs two synchroniser edges, then up to one full divided period to reach a falling edge, then half a period before the first output pulse. Checks after an enable change wait 4·H+6 cycles, where H is the half-period. Checks after a disable wait 2·H+4 cycles before confirming that pulses have stopped.

A power-down is due low after exactly three rising edges, and the bench checks it on the falling edge that follows the third. A pulse monitor measures every high and low run on each output throughout the run. It is muted only for the pulse that a power-down is allowed to cut.

// File: rtl/oeg_pkg.sv
// Package: shared types for the clock output enable gate.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package oeg_pkg;

    // Gate state held per channel
    typedef enum logic {
        GATE_CLOSED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_e;

endpackage

// File: rtl/oeg_sync.sv
// Module: multi-stage synchroniser for a vector of control bits.
// Brings register-domain bits into the clk domain through STAGES flops
// per bit. Assumes STAGES >= 1 and a synchronous active-low reset to 0.
module oeg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Later stages shift the value along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/oeg_chan.sv
// Module: one channel of the output enable gate.
// Detects the falling edge of its divided clock and only then loads the
// synchronised enable into the gate, so the output never carries a
// clipped pulse. Power-down clears the gate and the output at once.
// Assumes div_i is synchronous to clk and low for at least one sample.
module oeg_chan
    import oeg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic div_i,
    input  logic en_s_i,
    input  logic pd_s_i,
    output logic clk_o,
    output logic gate_o,
    output logic fall_o
);

    logic  div_prev_q;
    gate_e gate_q;
    logic  fall_w;

    assign fall_w = div_prev_q & ~div_i;

    // Remember last divided-clock sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) div_prev_q <= 1'b0;
        else        div_prev_q <= div_i;
    end

    // Gate changes state only at a falling edge; power-down closes it
    always_ff @(posedge clk) begin
        if (!rst_n)       gate_q <= GATE_CLOSED;
        else if (pd_s_i)  gate_q <= GATE_CLOSED;
        else if (fall_w)  gate_q <= en_s_i ? GATE_OPEN : GATE_CLOSED;
    end

    // Registered output: divided clock passed through the gate
    always_ff @(posedge clk) begin
        if (!rst_n) clk_o <= 1'b0;
        else        clk_o <= div_i & (gate_q == GATE_OPEN) & ~pd_s_i;
    end

    assign gate_o = (gate_q == GATE_OPEN);
    assign fall_o = fall_w;

endmodule

// File: rtl/oeg_gate.sv
// Module: top of the clock output enable gate, N_CHAN channels.
// Synchronises enable and power-down bits, then gates each divided
// clock at its own falling edge. Channels with equal ratio and phase
// switch on the same cycle because they share synchroniser latency.
// Assumes divided clocks are generated synchronously to clk.
module oeg_gate #(
    parameter int N_CHAN      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CHAN-1:0] div_clk_i,
    input  logic [N_CHAN-1:0] en_i,
    input  logic [N_CHAN-1:0] pd_i,
    output logic [N_CHAN-1:0] clk_o
);

    localparam int CtrlW = 2 * N_CHAN;

    logic [CtrlW-1:0]  ctrl_s;
    logic [N_CHAN-1:0] en_s;
    logic [N_CHAN-1:0] pd_s;
    logic [N_CHAN-1:0] gate_w;
    logic [N_CHAN-1:0] fall_w;

    // One synchroniser bank for all control bits
    oeg_sync #(
        .WIDTH  (CtrlW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({pd_i, en_i}),
        .q_o   (ctrl_s)
    );

    assign en_s = ctrl_s[N_CHAN-1:0];
    assign pd_s = ctrl_s[CtrlW-1:N_CHAN];

    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
            oeg_chan u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .div_i  (div_clk_i[c]),
                .en_s_i (en_s[c]),
                .pd_s_i (pd_s[c]),
                .clk_o  (clk_o[c]),
                .gate_o (gate_w[c]),
                .fall_o (fall_w[c])
            );
        end
    endgenerate

endmodule

// File: rtl/oeg_gate_chk.sv
// Module: assertion checker for oeg_gate, bound to every instance.
// Relates divided clocks, synchronised power-down, gate state and
// outputs over time. Assumes the synchronous active-low reset of the top.
module oeg_gate_chk #(
    parameter int N_CHAN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_CHAN-1:0] div_clk_i,
    input logic [N_CHAN-1:0] pd_s,
    input logic [N_CHAN-1:0] gate,
    input logic [N_CHAN-1:0] fall,
    input logic [N_CHAN-1:0] clk_o
);

    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_chk
            // R7: synchronised power-down leaves the output low next cycle
            p_pd_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
                pd_s[c] |=> !clk_o[c]);

            // R5: without a falling edge the gate keeps its state
            p_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!fall[c] && !pd_s[c]) |=> $stable(gate[c]));

            // R3: the gate opens only after a low sample of the divided clock
            p_open_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(gate[c]) |-> !$past(div_clk_i[c]));

            // R2: an output rise follows a divided-clock rise
            p_no_runt_r2: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(clk_o[c]) |-> ($past(div_clk_i[c]) && !$past(div_clk_i[c], 2)));

            // R4: an output fall without power-down tracks a divided-clock fall
            p_full_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(clk_o[c]) && !$past(pd_s[c])) |-> !$past(div_clk_i[c]));
        end
    endgenerate

endmodule

bind oeg_gate oeg_gate_chk #(.N_CHAN(N_CHAN)) u_oeg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_clk_i (div_clk_i),
    .pd_s      (pd_s),
    .gate      (gate_w),
    .fall      (fall_w),
    .clk_o     (clk_o)
);

// File: tb/oeg_gate_bench.sv
// Bench: sweeps enable, disable and power-down over every divided-clock
// phase of four channels (half-periods 2,2,3,5) and measures every pulse.
module oeg_gate_bench;

    localparam int NC = 4;
    localparam int HP [NC] = '{2, 2, 3, 5};

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NC-1:0] div;
    logic [NC-1:0] en;
    logic [NC-1:0] pd;
    logic [NC-1:0] clk_o;

    int   cnt    [NC];
    bit   mon_on [NC];
    bit   chk_eq [NC];
    int   run    [NC];
    logic last   [NC];
    int   rises  [NC];
    bit   hold;
    bit   chk_pair;
    int   checks;
    int   errors;

    always #4 clk = ~clk;

    oeg_gate #(.N_CHAN(NC), .SYNC_STAGES(2)) u_oeg_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_clk_i (div),
        .en_i      (en),
        .pd_i      (pd),
        .clk_o     (clk_o)
    );

    task automatic fail(input string req, input int act, input int exp);
        errors++;
        $display("FAIL %s actual %0d expected %0d", req, act, exp);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) fail(req, act, exp);
    endtask

    task automatic wait_phase(input int ch, input int ph);
        do @(posedge clk); while (cnt[ch] != ph);
    endtask

    // Pulse monitor and divided-clock model, both on the falling edge
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            for (int i = 0; i < NC; i++) begin
                if (clk_o[i] !== last[i]) begin
                    if (mon_on[i]) begin
                        checks++;
                        if (last[i] === 1'b1 && run[i] != HP[i])
                            fail($sformatf("R2 high pulse ch%0d", i), run[i], HP[i]);
                        if (last[i] === 1'b0 && run[i] < HP[i])
                            fail($sformatf("R2 low pulse ch%0d", i), run[i], HP[i]);
                    end
                    if (clk_o[i] === 1'b1) rises[i]++;
                    run[i]  = 1;
                    last[i] = clk_o[i];
                end else begin
                    run[i]++;
                end
                if (chk_eq[i]) begin
                    checks++;
                    if (clk_o[i] !== div[i])
                        fail($sformatf("R2 copy ch%0d", i), int'(clk_o[i]), int'(div[i]));
                end
            end
            if (chk_pair) begin
                checks++;
                if (clk_o[0] !== clk_o[1])
                    fail("R6 pair", int'(clk_o[0]), int'(clk_o[1]));
            end
        end
        if (!hold) begin
            for (int i = 0; i < NC; i++) begin
                cnt[i] = (cnt[i] + 1) % (2 * HP[i]);
                div[i] = (cnt[i] < HP[i]);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r;
        int r0;
        int r1;
        checks = 0; errors = 0; hold = 0; chk_pair = 0;
        for (int i = 0; i < NC; i++) begin
            cnt[i] = 0; div[i] = 1'b1; mon_on[i] = 1; chk_eq[i] = 0;
            run[i] = 0; last[i] = 1'b0; rises[i] = 0;
        end
        rst_n = 1'b0; en = '0; pd = '0;
        repeat (5) @(negedge clk);
        check("R1 outputs in reset", int'(clk_o), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 outputs after reset", int'(clk_o), 0);

        // R3, R4, R2: enable and disable at every phase of every channel
        for (int ch = 0; ch < NC; ch++) begin
            for (int off = 0; off < 2 * HP[ch]; off++) begin
                r = rises[ch];
                wait_phase(ch, off);
                @(negedge clk) en[ch] = 1'b1;
                repeat (4 * HP[ch] + 6) @(negedge clk);
                checks++;
                if (rises[ch] <= r) fail($sformatf("R3 start ch%0d", ch), rises[ch], r + 1);
                chk_eq[ch] = 1;
                repeat (4 * HP[ch]) @(negedge clk);
                chk_eq[ch] = 0;
                wait_phase(ch, off);
                @(negedge clk) en[ch] = 1'b0;
                repeat (2 * HP[ch] + 4) @(negedge clk);
                r = rises[ch];
                repeat (4 * HP[ch]) @(negedge clk);
                check($sformatf("R4 stopped ch%0d", ch), rises[ch], r);
                check($sformatf("R4 low ch%0d", ch), int'(clk_o[ch]), 0);
            end
        end

        // R6: equal-ratio channels switch together at every phase
        for (int off = 0; off < 2 * HP[0]; off++) begin
            r0 = rises[0]; r1 = rises[1];
            wait_phase(0, off);
            @(negedge clk) en[1:0] = 2'b11;
            chk_pair = 1;
            repeat (16) @(negedge clk);
            wait_phase(0, (off + 1) % (2 * HP[0]));
            @(negedge clk) en[1:0] = 2'b00;
            repeat (16) @(negedge clk);
            chk_pair = 0;
            check("R6 both started", int'(rises[0] > r0 && rises[1] > r1), 1);
        end

        // R9: one channel alone leaves its neighbour idle
        r0 = rises[0]; r1 = rises[1];
        @(negedge clk) en[1] = 1'b1;
        repeat (20) @(negedge clk);
        check("R9 neighbour idle", rises[0], r0);
        check("R9 channel running", int'(rises[1] > r1), 1);
        @(negedge clk) en[1] = 1'b0;
        repeat (20) @(negedge clk);

        // R5: divided clock held low, enable has no effect
        r = rises[2];
        wait_phase(2, HP[2]);
        hold = 1;
        @(negedge clk) en[2] = 1'b1;
        repeat (10) @(negedge clk);
        check("R5 held low out", int'(clk_o[2]), 0);
        check("R5 held low pulses", rises[2], r);
        en[2] = 1'b0;
        repeat (4) @(negedge clk);
        @(posedge clk) hold = 0;
        repeat (10) @(negedge clk);

        // R5: divided clock held high, enable has no effect until released
        r = rises[2];
        wait_phase(2, 0);
        hold = 1;
        @(negedge clk) en[2] = 1'b1;
        repeat (10) @(negedge clk);
        check("R5 held high out", int'(clk_o[2]), 0);
        check("R5 held high pulses", rises[2], r);
        @(posedge clk) hold = 0;
        repeat (4 * HP[2] + 6) @(negedge clk);
        check("R3 start after release", int'(rises[2] > r), 1);
        @(negedge clk) en[2] = 1'b0;
        repeat (20) @(negedge clk);

        // R7, R8: power-down at every phase of channel 3 while enabled
        @(negedge clk) en[3] = 1'b1;
        repeat (30) @(negedge clk);
        for (int off = 0; off < 2 * HP[3]; off++) begin
            wait_phase(3, off);
            @(negedge clk) begin
                pd[3] = 1'b1;
                mon_on[3] = 0;
            end
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R7 forced low", int'(clk_o[3]), 0);
            r = rises[3];
            repeat (2 * HP[3]) @(negedge clk);
            check("R7 stays low", rises[3], r);
            check("R7 stays low out", int'(clk_o[3]), 0);
            mon_on[3] = 1;
            pd[3] = 1'b0;
            repeat (4 * HP[3] + 6) @(negedge clk);
            check("R8 resumed", int'(rises[3] > r), 1);
        end
        @(negedge clk) en[3] = 1'b0;
        repeat (20) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule